// File: doc/BRIEF.md
# Layered State-Enable Register Bank (Index 3)

This block holds the fourth state-enable control register of each privilege level: a 64-bit machine copy, a 64-bit hypervisor copy and a 32-bit supervisor copy. The pipeline presents one CSR request per cycle, tagged with the current privilege level and the virtualization flag. The block decodes the address and checks whether the requester may touch the register. It returns the visible value and any fault flag in the same cycle, and it commits a legal write at the next clock edge.

Each level is gated by the level above it. Hypervisor bits can only be set where the machine copy allows them, and hypervisor reads are masked by the machine copy. The supervisor copy has three views. Machine mode sees it whole. Non-virtualized supervisor mode sees it masked by the machine copy. A guest in VS-mode sees it masked by both the machine and the hypervisor copies. Bit 63 of the machine and hypervisor copies gates all access from lower levels. A denied access raises either an illegal-instruction fault or a virtual-instruction fault. The parameters pick which bits are implemented and which are hard-wired to one.

Top module: `stateen3_bank`

## Requirements
- R1: After reset, the machine copy reads as M_RO1_MASK & IMPL_MASK. The hypervisor copy reads as H_RO1_MASK & M_RO1_MASK & IMPL_MASK. The supervisor copy reads as 0.
- R2: A legal write to the machine copy (address 0x30f) stores the written bits in IMPL_MASK positions. Hard-wired-one positions stay 1. All other bits read 0.
- R3: A legal write to the hypervisor copy (address 0x60f) stores, for each implemented bit, the written bit ANDed with the current machine bit. Bit 63 is therefore forced to 0 while the machine bit 63 is 0. A hypervisor bit is hard-wired to one only where H_RO1_MASK and M_RO1_MASK both have it.
- R4: A read of the hypervisor copy returns the stored value ANDed with the current machine copy. Clearing a machine bit hides the hypervisor bit without erasing it.
- R5: A read of the supervisor copy (address 0x10f) returns the following. In M-mode it returns the stored value. In HS-mode it returns the stored value ANDed with machine bits 31:0. In VS-mode it returns the stored value ANDed with machine and hypervisor bits 31:0. Bits 63:32 of the read data are 0.
- R6: A legal write to the supervisor copy changes only the implemented bits (S_IMPL_MASK) that are set in the requester's view mask from R5. All other stored bits keep their value.
- R7: Read data and fault flags reflect the state before the request's own write, in the same cycle. A write becomes visible on the next cycle.
- R8: Any access to the machine copy from a level other than M (priv encoding 2'b11) raises the illegal fault.
- R9: From below M, an access to the hypervisor or supervisor copy raises the illegal fault when machine bit 63 is 0. It also raises the illegal fault from non-virtualized U-mode (2'b00) or the reserved level 2'b10, which is treated as U.
- R10: With machine bit 63 set, an access to the hypervisor copy from VS or VU raises the virtual fault. From HS (2'b01, not virtualized) the access succeeds.
- R11: With machine bit 63 set, an access to the supervisor copy raises the virtual fault from VS when hypervisor bit 63 is 0, and raises it from VU always. From VS with hypervisor bit 63 set, the access succeeds.
- R12: At most one fault flag is high. A faulting request returns read data 0, and a faulting write changes no register.
- R13: An address outside the three copies gives hit 0, read data 0 and no fault.
- R14: M-mode never faults on any of the three copies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | CSR request valid |
| we_i | input | 1 | Request is a write |
| addr_i | input | 12 | CSR address |
| priv_i | input | 2 | Current level: 3 M, 1 S, 0 U, 2 reserved |
| virt_i | input | 1 | Virtualization flag (VS/VU when set) |
| wdata_i | input | 64 | Write data |
| rdata_o | output | 64 | Visible read value, 0 on fault or miss |
| hit_o | output | 1 | Address selects one of the three copies |
| ill_o | output | 1 | Illegal-instruction fault |
| vfault_o | output | 1 | Virtual-instruction fault |

## Verification
The bench builds the bank with IMPL_MASK = 64'h8000_0000_0000_000F, so the machine and hypervisor copies have a writable low nibble as well as bit 63. It sets S_IMPL_MASK = 32'hF, which brings the masked supervisor views and partial guest writes within reach. It sets M_RO1_MASK = 64'h8 and H_RO1_MASK = 64'hC. Bit 3 is then hard-wired to one in both copies. Bit 2 is hard-wired in the hypervisor request only, so it must fall back to a plain writable bit. These values exercise the rule that a hypervisor bit is hard-wired to one only where the machine bit is too. With the default masks, only bit 63 would exist and the supervisor copy would read as constant zero.

// File: rtl/stateen3_pkg.sv
`timescale 1ns/1ps
package stateen3_pkg;
  localparam int unsigned MW  = 64;
  localparam int unsigned SW  = 32;
  localparam int unsigned AW  = 12;
  localparam int unsigned SE0 = MW - 1;

  localparam logic [AW-1:0] ADDR_M = 12'h30f;
  localparam logic [AW-1:0] ADDR_H = 12'h60f;
  localparam logic [AW-1:0] ADDR_S = 12'h10f;

  typedef enum logic [1:0] {
    LVL_U = 2'b00,
    LVL_S = 2'b01,
    LVL_R = 2'b10,
    LVL_M = 2'b11
  } lvl_e;

  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_M,
    SEL_H,
    SEL_S
  } sel_e;

  typedef struct packed {
    logic ill;
    logic vf;
  } fault_t;
endpackage

// File: rtl/stateen3_decode.sv
`timescale 1ns/1ps
module stateen3_decode
  import stateen3_pkg::*;
(
  input  logic [AW-1:0] addr_i,
  output sel_e          sel_o
);
  always_comb begin
    unique case (addr_i)
      ADDR_M:  sel_o = SEL_M;
      ADDR_H:  sel_o = SEL_H;
      ADDR_S:  sel_o = SEL_S;
      default: sel_o = SEL_NONE;
    endcase
  end
endmodule

// File: rtl/stateen3_access.sv
`timescale 1ns/1ps
module stateen3_access
  import stateen3_pkg::*;
(
  input  sel_e       sel_i,
  input  logic [1:0] priv_i,
  input  logic       virt_i,
  input  logic       m_se0_i,
  input  logic       h_se0_i,
  output fault_t     fault_o
);
  logic is_m;
  assign is_m = (priv_i == LVL_M);

  always_comb begin
    fault_o = '0;
    unique case (sel_i)
      SEL_M: fault_o.ill = !is_m;
      SEL_H, SEL_S: begin
        if (!is_m) begin
          if (!m_se0_i) begin
            fault_o.ill = 1'b1;
          end else if (!virt_i) begin
            // reserved level behaves as U
            fault_o.ill = (priv_i != LVL_S);
          end else if (sel_i == SEL_S && priv_i == LVL_S && h_se0_i) begin
            fault_o.vf = 1'b0;
          end else begin
            fault_o.vf = 1'b1;
          end
        end
      end
      default: fault_o = '0;
    endcase
  end
endmodule

// File: rtl/stateen3_regs.sv
`timescale 1ns/1ps
module stateen3_regs
  import stateen3_pkg::*;
#(
  parameter logic [MW-1:0] M_RW  = '0,
  parameter logic [MW-1:0] M_ONE = '0,
  parameter logic [MW-1:0] H_RW  = '0,
  parameter logic [MW-1:0] H_ONE = '0,
  parameter logic [SW-1:0] S_RW  = '0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_m_i,
  input  logic          wr_h_i,
  input  logic          wr_s_i,
  input  logic [MW-1:0] wdata_i,
  input  logic [SW-1:0] s_wmask_i,
  output logic [MW-1:0] m_q_o,
  output logic [MW-1:0] h_q_o,
  output logic [SW-1:0] s_q_o
);
  for (genvar i = 0; i < MW; i++) begin : g_mbit
    if (M_ONE[i]) begin : g_one
      assign m_q_o[i] = 1'b1;
    end else if (M_RW[i]) begin : g_rw
      logic b_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     b_q <= 1'b0;
        else if (wr_m_i) b_q <= wdata_i[i];
      end
      assign m_q_o[i] = b_q;
    end else begin : g_zero
      assign m_q_o[i] = 1'b0;
    end
  end

  for (genvar i = 0; i < MW; i++) begin : g_hbit
    if (H_ONE[i]) begin : g_one
      assign h_q_o[i] = 1'b1;
    end else if (H_RW[i]) begin : g_rw
      logic b_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     b_q <= 1'b0;
        else if (wr_h_i) b_q <= wdata_i[i] & m_q_o[i];
      end
      assign h_q_o[i] = b_q;
    end else begin : g_zero
      assign h_q_o[i] = 1'b0;
    end
  end

  for (genvar i = 0; i < SW; i++) begin : g_sbit
    if (S_RW[i]) begin : g_rw
      logic b_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                     b_q <= 1'b0;
        else if (wr_s_i && s_wmask_i[i]) b_q <= wdata_i[i];
      end
      assign s_q_o[i] = b_q;
    end else begin : g_zero
      assign s_q_o[i] = 1'b0;
    end
  end
endmodule

// File: rtl/stateen3_rview.sv
`timescale 1ns/1ps
module stateen3_rview
  import stateen3_pkg::*;
(
  input  sel_e          sel_i,
  input  logic [1:0]    priv_i,
  input  logic          virt_i,
  input  logic          blocked_i,
  input  logic [MW-1:0] m_q_i,
  input  logic [MW-1:0] h_q_i,
  input  logic [SW-1:0] s_q_i,
  output logic [SW-1:0] s_view_o,
  output logic [MW-1:0] rdata_o
);
  // an enable never restricts its own level
  always_comb begin
    if (priv_i == LVL_M)  s_view_o = '1;
    else if (virt_i)      s_view_o = m_q_i[SW-1:0] & h_q_i[SW-1:0];
    else                  s_view_o = m_q_i[SW-1:0];
  end

  always_comb begin
    rdata_o = '0;
    if (!blocked_i) begin
      unique case (sel_i)
        SEL_M:   rdata_o = m_q_i;
        SEL_H:   rdata_o = h_q_i & m_q_i;
        SEL_S:   rdata_o[SW-1:0] = s_q_i & s_view_o;
        default: rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/stateen3_bank.sv
`timescale 1ns/1ps
module stateen3_bank
  import stateen3_pkg::*;
#(
  parameter logic [MW-1:0] IMPL_MASK   = {1'b1, {(MW-1){1'b0}}},
  parameter logic [MW-1:0] M_RO1_MASK  = '0,
  parameter logic [MW-1:0] H_RO1_MASK  = '0,
  parameter logic [SW-1:0] S_IMPL_MASK = '0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [1:0]    priv_i,
  input  logic          virt_i,
  input  logic [MW-1:0] wdata_i,
  output logic [MW-1:0] rdata_o,
  output logic          hit_o,
  output logic          ill_o,
  output logic          vfault_o
);
  localparam logic [MW-1:0] M_ONE = M_RO1_MASK & IMPL_MASK;
  localparam logic [MW-1:0] M_RW  = IMPL_MASK & ~M_ONE;
  // hypervisor hard-wired one only where machine is hard-wired one
  localparam logic [MW-1:0] H_ONE = H_RO1_MASK & M_ONE;
  localparam logic [MW-1:0] H_RW  = IMPL_MASK & ~H_ONE;

  sel_e          sel;
  fault_t        fault;
  logic          blocked;
  logic          wr_ok;
  logic [MW-1:0] m_q, h_q, rdata;
  logic [SW-1:0] s_q, s_view;

  stateen3_decode u_dec (
    .addr_i (addr_i),
    .sel_o  (sel)
  );

  stateen3_access u_acc (
    .sel_i   (sel),
    .priv_i  (priv_i),
    .virt_i  (virt_i),
    .m_se0_i (m_q[SE0]),
    .h_se0_i (h_q[SE0] & m_q[SE0]),
    .fault_o (fault)
  );

  assign blocked = fault.ill | fault.vf;
  assign wr_ok   = req_i & we_i & !blocked;

  stateen3_regs #(
    .M_RW  (M_RW),
    .M_ONE (M_ONE),
    .H_RW  (H_RW),
    .H_ONE (H_ONE),
    .S_RW  (S_IMPL_MASK)
  ) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_m_i    (wr_ok && sel == SEL_M),
    .wr_h_i    (wr_ok && sel == SEL_H),
    .wr_s_i    (wr_ok && sel == SEL_S),
    .wdata_i   (wdata_i),
    .s_wmask_i (s_view),
    .m_q_o     (m_q),
    .h_q_o     (h_q),
    .s_q_o     (s_q)
  );

  stateen3_rview u_view (
    .sel_i     (sel),
    .priv_i    (priv_i),
    .virt_i    (virt_i),
    .blocked_i (blocked),
    .m_q_i     (m_q),
    .h_q_i     (h_q),
    .s_q_i     (s_q),
    .s_view_o  (s_view),
    .rdata_o   (rdata)
  );

  assign rdata_o  = req_i ? rdata : '0;
  assign hit_o    = req_i && (sel != SEL_NONE);
  assign ill_o    = req_i && fault.ill;
  assign vfault_o = req_i && fault.vf;
endmodule

// File: rtl/stateen3_chk.sv
`timescale 1ns/1ps
module stateen3_chk
  import stateen3_pkg::*;
(
  input logic          clk_i,
  input logic          rst_ni,
  input logic          req_i,
  input logic          we_i,
  input logic [AW-1:0] addr_i,
  input logic [1:0]    priv_i,
  input logic          virt_i,
  input logic [MW-1:0] rdata_o,
  input logic          hit_o,
  input logic          ill_o,
  input logic          vfault_o,
  input logic [MW-1:0] m_q,
  input logic [MW-1:0] h_q,
  input logic [SW-1:0] s_q
);
  logic ok;
  assign ok = req_i && !ill_o && !vfault_o;

  // R12
  fault_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ill_o && vfault_o));

  // R12
  fault_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && we_i && (ill_o || vfault_o) |=> $stable(m_q) && $stable(h_q) && $stable(s_q));

  // R14
  m_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && priv_i == 2'b11 |-> !ill_o && !vfault_o);

  // R8
  m_priv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && addr_i == ADDR_M && priv_i != 2'b11 |-> ill_o);

  // R3
  h_se0_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ok && we_i && addr_i == ADDR_H && !m_q[SE0] |=> !h_q[SE0]);

  // R4
  h_read_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ok && addr_i == ADDR_H |-> (rdata_o & ~m_q) == '0);

  // R5
  vs_view_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ok && virt_i && priv_i == 2'b01 && addr_i == ADDR_S |->
      (rdata_o[SW-1:0] & ~(h_q[SW-1:0] & m_q[SW-1:0])) == '0 && rdata_o[MW-1:SW] == '0);

  // R13
  miss_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && !hit_o |-> rdata_o == '0 && !ill_o && !vfault_o);
endmodule

bind stateen3_bank stateen3_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .req_i    (req_i),
  .we_i     (we_i),
  .addr_i   (addr_i),
  .priv_i   (priv_i),
  .virt_i   (virt_i),
  .rdata_o  (rdata_o),
  .hit_o    (hit_o),
  .ill_o    (ill_o),
  .vfault_o (vfault_o),
  .m_q      (m_q),
  .h_q      (h_q),
  .s_q      (s_q)
);

// File: tb/sim_stateen3_bank.sv
`timescale 1ns/1ps
module sim_stateen3_bank;
  localparam logic [63:0] IMPL  = 64'h8000_0000_0000_000F;
  localparam logic [63:0] MRO1  = 64'h0000_0000_0000_0008;
  localparam logic [63:0] HRO1  = 64'h0000_0000_0000_000C;
  localparam logic [31:0] SIMPL = 32'h0000_000F;
  localparam logic [63:0] MONE  = MRO1 & IMPL;
  localparam logic [63:0] HONE  = HRO1 & MONE;
  localparam logic [11:0] AM = 12'h30f, AH = 12'h60f, AS = 12'h10f;
  localparam logic [1:0]  PM = 2'b11, PS = 2'b01, PU = 2'b00, PR = 2'b10;
  localparam logic [63:0] ONES = '1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0, virt = 1'b0;
  logic [11:0] addr = '0;
  logic [1:0]  priv = '0;
  logic [63:0] wdata = '0;
  logic [63:0] rdata;
  logic        hit, ill, vf;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference state
  logic [63:0] rm, rh;
  logic [31:0] rs;

  always #5 clk = ~clk;

  stateen3_bank #(
    .IMPL_MASK   (IMPL),
    .M_RO1_MASK  (MRO1),
    .H_RO1_MASK  (HRO1),
    .S_IMPL_MASK (SIMPL)
  ) u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .priv_i(priv), .virt_i(virt), .wdata_i(wdata), .rdata_o(rdata),
    .hit_o(hit), .ill_o(ill), .vfault_o(vf)
  );

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  task automatic op(input string tag, input logic [11:0] a, input logic [1:0] p,
                    input logic v, input logic w, input logic [63:0] d);
    logic e_hit, e_ill, e_vf, is_m;
    logic [63:0] e_rd;
    logic [31:0] sg;
    @(negedge clk);
    req = 1'b1; we = w; addr = a; priv = p; virt = v; wdata = d;
    #1;
    is_m  = (p == PM);
    e_hit = (a == AM) || (a == AH) || (a == AS);
    e_ill = 1'b0; e_vf = 1'b0;
    if (a == AM) e_ill = !is_m;
    else if ((a == AH || a == AS) && !is_m) begin
      if (!rm[63])                                  e_ill = 1'b1;
      else if (!v)                                  e_ill = (p != PS);
      else if (a == AS && p == PS && rh[63])        e_vf  = 1'b0;
      else                                          e_vf  = 1'b1;
    end
    sg = is_m ? 32'hFFFF_FFFF : (v ? (rm[31:0] & rh[31:0]) : rm[31:0]);
    e_rd = '0;
    if (e_hit && !e_ill && !e_vf) begin
      if (a == AM)      e_rd = rm;
      else if (a == AH) e_rd = rh & rm;
      else              e_rd = {32'h0, rs & sg};
    end
    checks++;
    if (rdata !== e_rd || hit !== e_hit || ill !== e_ill || vf !== e_vf) begin
      errors++;
      $display("FAIL %s a=%h p=%0d v=%0b w=%0b rdata=%h exp=%h hit=%b exp=%b ill=%b exp=%b vf=%b exp=%b",
               tag, a, p, v, w, rdata, e_rd, hit, e_hit, ill, e_ill, vf, e_vf);
    end
    @(posedge clk);
    if (w && e_hit && !e_ill && !e_vf) begin
      if (a == AM)      rm = (d & IMPL & ~MONE) | MONE;
      else if (a == AH) rh = (d & rm & IMPL & ~HONE) | HONE;
      else              rs = (rs & ~(SIMPL & sg)) | (d[31:0] & SIMPL & sg);
    end
  endtask

  task automatic lit(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s rdata=%h exp=%h", tag, got, exp);
    end
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    rm = MONE; rh = HONE; rs = '0;
    #23;
    @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    op("R1", AM, PM, 0, 0, 0); lit("R1", rdata, 64'h8);
    op("R1", AH, PM, 0, 0, 0); lit("R1", rdata, 64'h8);
    op("R1", AS, PM, 0, 0, 0); lit("R1", rdata, 64'h0);
    // R8 machine copy below M
    op("R8", AM, PS, 0, 0, 0);
    op("R8", AM, PS, 1, 0, 0);
    // R9 machine SE0 clear
    op("R9", AH, PS, 0, 0, 0);
    op("R9", AS, PS, 1, 0, 0);
    op("R9", AS, PU, 0, 0, 0);
    // R2 R14 machine write
    op("R2", AM, PM, 0, 1, ONES);
    op("R2", AM, PM, 0, 0, 0); lit("R2", rdata, 64'h8000_0000_0000_000F);
    // R3 hypervisor legalization
    op("R3", AH, PM, 0, 1, 0);
    op("R3", AH, PM, 0, 0, 0); lit("R3", rdata, 64'h8);
    op("R3", AH, PM, 0, 1, ONES);
    op("R3", AH, PM, 0, 0, 0); lit("R3", rdata, 64'h8000_0000_0000_000F);
    // R4 masking by machine copy
    op("R4", AM, PM, 0, 1, 0);
    op("R4", AH, PM, 0, 0, 0); lit("R4", rdata, 64'h8);
    op("R4", AM, PM, 0, 1, ONES);
    op("R4", AH, PM, 0, 0, 0); lit("R4", rdata, 64'h8000_0000_0000_000F);
    op("R3", AM, PM, 0, 1, 0);
    op("R3", AH, PM, 0, 1, ONES);
    op("R3", AM, PM, 0, 1, ONES);
    op("R3", AH, PM, 0, 0, 0); lit("R3", rdata, 64'h8);
    // R10 hypervisor copy from lower levels
    op("R10", AH, PS, 0, 0, 0);
    op("R10", AH, PS, 1, 0, 0);
    op("R10", AH, PU, 1, 0, 0);
    op("R9",  AH, PU, 0, 0, 0);
    op("R9",  AH, PR, 0, 0, 0);
    // R5 R6 supervisor views
    op("R6", AS, PM, 0, 1, 64'hF);
    op("R5", AM, PM, 0, 1, 64'h8000_0000_0000_0005);
    op("R5", AH, PM, 0, 1, 64'h8000_0000_0000_0001);
    op("R5", AS, PS, 0, 0, 0); lit("R5", rdata, 64'hD);
    op("R5", AS, PS, 1, 0, 0); lit("R5", rdata, 64'h9);
    op("R5", AS, PM, 0, 0, 0); lit("R5", rdata, 64'hF);
    op("R6", AS, PS, 1, 1, 0);
    op("R6", AS, PM, 0, 0, 0); lit("R6", rdata, 64'h6);
    op("R6", AS, PS, 0, 1, 0);
    op("R6", AS, PM, 0, 0, 0); lit("R6", rdata, 64'h2);
    // R7 read before own write
    op("R7", AS, PM, 0, 1, 64'h5); lit("R7", rdata, 64'h2);
    op("R7", AS, PM, 0, 0, 0);     lit("R7", rdata, 64'h5);
    // R11 guest access to supervisor copy
    op("R11", AH, PM, 0, 1, 64'h1);
    op("R11", AS, PS, 1, 0, 0);
    op("R11", AS, PU, 1, 0, 0);
    op("R11", AH, PM, 0, 1, 64'h8000_0000_0000_0001);
    op("R11", AS, PS, 1, 0, 0);
    op("R11", AS, PU, 1, 0, 0);
    // R12 faulting writes leave state
    op("R12", AM, PS, 0, 1, 0);
    op("R12", AM, PM, 0, 0, 0); lit("R12", rdata, 64'h8000_0000_0000_000D);
    op("R12", AH, PS, 1, 1, 0);
    op("R12", AH, PM, 0, 0, 0); lit("R12", rdata, 64'h8000_0000_0000_0009);
    // R13 miss
    op("R13", 12'h123, PM, 0, 1, ONES);
    op("R13", 12'h30e, PS, 1, 0, 0);

    // mixed sweep against the model
    for (int i = 0; i < 4000; i++) begin
      logic [11:0] a;
      int k;
      k = $urandom_range(0, 4);
      a = (k == 0) ? AM : (k == 1) ? AH : (k <= 3) ? AS : 12'h7c0;
      op("R12", a, 2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)),
         1'($urandom_range(0, 1)), {$urandom, $urandom});
    end

    @(negedge clk);
    req = 1'b0;
    finish_up();
  end
endmodule